// File: doc/BRIEF.md
# Block-transfer mailbox host register window

This block is the host-facing side of a byte-wide block-transfer mailbox. A host reaches it through a four-offset window decoded on two address bits. Offset 0 holds control and status. Offset 1 is a streaming data port. Offset 2 is the interrupt-mask slot, which is handled elsewhere. Offset 3 is unused. The host streams a request into an inbound buffer through the data port. It then rings a doorbell bit in the control register. The block marks itself busy and gives a one-cycle request pulse to a message engine.

The engine reads the request bytes through its own read port. It writes the response bytes into an outbound buffer and commits a length. The host is then told that a response is waiting and drains the buffer byte by byte through the same data port. Once the last byte has been read, both outbound pointers return to zero.

Control writes are write-1-to-act, and each bit has its own effect: clear a pointer, clear an attention flag, toggle the host-busy flag or ring the doorbell. Both buffers are simple dual-port memories of parameterised depth, written so that block RAM can be inferred.

Top module: `bt_host_window`

## Requirements
- R1: After reset all flags are clear and both buffer lengths are zero; a control read returns 0x00 and a data read returns 0xFF.
- R2: A read strobe returns its value on `host_rdata` in the cycle after the strobe, and that value holds until the next read strobe. The control byte is laid out as bit7 BMC busy, bit6 host busy, bit4 SMS attention and bit3 response attention; all other bits read 0. Offset 2 reads 0x00 and offset 3 reads 0xFF. Writes to offsets 2 and 3 change no state.
- R3: A data-port write stores the byte at the current inbound count while the count is below DEPTH. The count, exported as `req_len`, increments on every data write and saturates at 2*DEPTH-1.
- R4: Writing a control byte with bit0 set zeroes the inbound count. Writing one with bit1 set zeroes the outbound read position and leaves the outbound length unchanged.
- R5: Writing a control byte with bit3 set clears response attention, and with bit4 set clears SMS attention. An engine set in the same cycle wins. `eng_sms_set` sets SMS attention.
- R6: Writing a control byte with bit6 set inverts the host-busy flag.
- R7: Writing a control byte with bit2 set sets BMC busy. In the next cycle `req_pulse` is high for exactly one cycle per doorbell write.
- R8: `eng_commit` loads the outbound length from `eng_commit_len`, limited to DEPTH. It zeroes the read position, clears BMC busy and sets response attention. A doorbell in the same cycle keeps BMC busy set.
- R9: A data-port read returns the outbound byte at the read position and advances the position. Reading the last byte zeroes both the position and the length.
- R10: A data-port read with no outbound byte pending returns 0xFF and changes no state.
- R11: Read side effects happen only in cycles with `host_rd` high. Idle cycles between reads do not move the read position.
- R12: The engine reads the inbound buffer at `eng_in_addr`, and the data appears on `eng_in_data` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Window offset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after the strobe |
| req_pulse | output | 1 | One-cycle request-ready pulse to the engine |
| req_len | output | AW+1 | Inbound byte count (overrun-capable) |
| eng_in_addr | input | AW | Engine read address into the inbound buffer |
| eng_in_data | output | 8 | Inbound byte, one cycle after the address |
| eng_out_we | input | 1 | Engine write enable for the outbound buffer |
| eng_out_addr | input | AW | Engine write address |
| eng_out_data | input | 8 | Engine write byte |
| eng_commit | input | 1 | Response loaded; start host drain |
| eng_commit_len | input | AW+1 | Response length in bytes |
| eng_sms_set | input | 1 | Raise SMS attention |

## Verification
The assertions check the following on every cycle:
- the doorbell always sets BMC busy and the request pulse;
- the host-busy flag flips on each toggle write;
- the inbound count steps by exactly one per data write below saturation;
- the outbound read position stays below the length unless both are zero;
- empty-port reads and offset 3 return 0xFF.

The cycle-accurate reference model in the bench shows what properties cannot. It shows that the returned bytes come out in order, that the pointers return to zero after the last byte, and that a mid-stream read-pointer clear replays the response. It also shows that saturation and the depth limit on commit behave as required, and that writes to the mask and unused offsets leave every observable state unchanged.

// File: rtl/bt_win_pkg.sv
package bt_win_pkg;
  localparam int CB_CLR_WR   = 0;
  localparam int CB_CLR_RD   = 1;
  localparam int CB_DOORBELL = 2;
  localparam int CB_RSP_ATN  = 3;
  localparam int CB_SMS_ATN  = 4;
  localparam int CB_HBUSY    = 6;
  localparam int CB_BBUSY    = 7;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_DATA = 2'd1,
    OFS_MASK = 2'd2,
    OFS_NONE = 2'd3
  } win_ofs_e;

  typedef struct packed {
    logic bbusy;
    logic hbusy;
    logic sms;
    logic rsp;
  } win_flags_t;

  function automatic logic [7:0] ctrl_byte(input win_flags_t f);
    logic [7:0] b;
    b = 8'h00;
    b[CB_BBUSY]   = f.bbusy;
    b[CB_HBUSY]   = f.hbusy;
    b[CB_SMS_ATN] = f.sms;
    b[CB_RSP_ATN] = f.rsp;
    return b;
  endfunction
endpackage

// File: rtl/bt_byte_ram.sv
module bt_byte_ram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bt_ctrl_flags.sv
module bt_ctrl_flags
  import bt_win_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       do_doorbell,
  input  logic       do_clr_rsp,
  input  logic       do_clr_sms,
  input  logic       do_toggle,
  input  logic       commit,
  input  logic       sms_set,
  output win_flags_t flags,
  output logic       req_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      req_pulse <= 1'b0;
    end else begin
      req_pulse <= do_doorbell;
      if (do_doorbell)     flags.bbusy <= 1'b1;
      else if (commit)     flags.bbusy <= 1'b0;
      if (commit)          flags.rsp   <= 1'b1;
      else if (do_clr_rsp) flags.rsp   <= 1'b0;
      if (sms_set)         flags.sms   <= 1'b1;
      else if (do_clr_sms) flags.sms   <= 1'b0;
      if (do_toggle)       flags.hbusy <= ~flags.hbusy;
    end
  end
endmodule

// File: rtl/bt_in_count.sv
module bt_in_count #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_data,
  input  logic          clr,
  output logic [CW-1:0] count,
  output logic          store_en
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] CMAX    = {CW{1'b1}};

  assign store_en = wr_data && (count < DEPTH_C);

  always_ff @(posedge clk) begin
    if (rst)                         count <= '0;
    else if (clr)                    count <= '0;
    else if (wr_data && count != CMAX) count <= count + CW'(1);
  end
endmodule

// File: rtl/bt_out_ptr.sv
module bt_out_ptr #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_data,
  input  logic          clr_rd,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  output logic [CW-1:0] pos,
  output logic [CW-1:0] len,
  output logic          rd_fire
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  assign rd_fire = rd_data && (pos < len);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      len <= '0;
    end else if (commit) begin
      len <= (commit_len > DEPTH_C) ? DEPTH_C : commit_len;
      pos <= '0;
    end else if (rd_fire) begin
      if (pos + CW'(1) == len) begin
        pos <= '0;
        len <= '0;
      end else begin
        pos <= pos + CW'(1);
      end
    end else if (clr_rd) begin
      pos <= '0;
    end
  end
endmodule

// File: rtl/bt_host_window.sv
module bt_host_window
  import bt_win_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          req_pulse,
  output logic [CW-1:0] req_len,
  input  logic [AW-1:0] eng_in_addr,
  output logic [7:0]    eng_in_data,
  input  logic          eng_out_we,
  input  logic [AW-1:0] eng_out_addr,
  input  logic [7:0]    eng_out_data,
  input  logic          eng_commit,
  input  logic [CW-1:0] eng_commit_len,
  input  logic          eng_sms_set
);
  win_ofs_e   ofs;
  logic       wr_ctrl, wr_data, rd_data;
  win_flags_t flags;
  logic [CW-1:0] in_len, out_pos, out_len;
  logic       in_store, rd_fire;
  logic [7:0] out_q;
  logic       rd_mem_q;
  logic [7:0] rd_const_q;

  assign ofs     = win_ofs_e'(host_addr);
  assign wr_ctrl = host_wr && (ofs == OFS_CTRL);
  assign wr_data = host_wr && (ofs == OFS_DATA);
  assign rd_data = host_rd && (ofs == OFS_DATA);

  bt_ctrl_flags u_flags (
    .clk         (clk),
    .rst         (rst),
    .do_doorbell (wr_ctrl && host_wdata[CB_DOORBELL]),
    .do_clr_rsp  (wr_ctrl && host_wdata[CB_RSP_ATN]),
    .do_clr_sms  (wr_ctrl && host_wdata[CB_SMS_ATN]),
    .do_toggle   (wr_ctrl && host_wdata[CB_HBUSY]),
    .commit      (eng_commit),
    .sms_set     (eng_sms_set),
    .flags       (flags),
    .req_pulse   (req_pulse)
  );

  bt_in_count #(.DEPTH(DEPTH)) u_in_cnt (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_data),
    .clr      (wr_ctrl && host_wdata[CB_CLR_WR]),
    .count    (in_len),
    .store_en (in_store)
  );

  bt_out_ptr #(.DEPTH(DEPTH)) u_out_ptr (
    .clk        (clk),
    .rst        (rst),
    .rd_data    (rd_data),
    .clr_rd     (wr_ctrl && host_wdata[CB_CLR_RD]),
    .commit     (eng_commit),
    .commit_len (eng_commit_len),
    .pos        (out_pos),
    .len        (out_len),
    .rd_fire    (rd_fire)
  );

  bt_byte_ram #(.DEPTH(DEPTH)) u_in_ram (
    .clk   (clk),
    .we    (in_store),
    .waddr (in_len[AW-1:0]),
    .wdata (host_wdata),
    .re    (1'b1),
    .raddr (eng_in_addr),
    .rdata (eng_in_data)
  );

  bt_byte_ram #(.DEPTH(DEPTH)) u_out_ram (
    .clk   (clk),
    .we    (eng_out_we),
    .waddr (eng_out_addr),
    .wdata (eng_out_data),
    .re    (rd_fire),
    .raddr (out_pos[AW-1:0]),
    .rdata (out_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_mem_q   <= 1'b0;
      rd_const_q <= 8'hFF;
    end else if (host_rd) begin
      rd_mem_q <= rd_fire;
      unique case (ofs)
        OFS_CTRL: rd_const_q <= ctrl_byte(flags);
        OFS_MASK: rd_const_q <= 8'h00;
        default:  rd_const_q <= 8'hFF;
      endcase
    end
  end

  assign host_rdata = rd_mem_q ? out_q : rd_const_q;
  assign req_len    = in_len;
endmodule

// File: rtl/bt_host_window_chk.sv
module bt_host_window_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    host_addr,
  input logic          host_wr,
  input logic          host_rd,
  input logic          wr_db,
  input logic          wr_tog,
  input logic [7:0]    host_rdata,
  input logic          req_pulse,
  input logic          bbusy,
  input logic          hbusy,
  input logic [CW-1:0] in_len,
  input logic [CW-1:0] out_pos,
  input logic [CW-1:0] out_len
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  assert_pulse_busy_R7: assert property (@(posedge clk) disable iff (rst)
    req_pulse |-> bbusy);

  assert_doorbell_R7: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd0 && wr_db) |=> (bbusy && req_pulse));

  assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd0 && wr_tog) |=> (hbusy != $past(hbusy)));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd1 && in_len != CMAX) |=> (in_len == CW'($past(in_len) + 1'b1)));

  assert_pos_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (out_pos < out_len) || (out_pos == '0 && out_len == '0));

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 2'd1 && out_len == '0) |=> (host_rdata == 8'hFF));

  assert_unused_ofs_R2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 2'd3) |=> (host_rdata == 8'hFF));
endmodule

bind bt_host_window bt_host_window_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .wr_db      (host_wdata[2]),
  .wr_tog     (host_wdata[6]),
  .host_rdata (host_rdata),
  .req_pulse  (req_pulse),
  .bbusy      (flags.bbusy),
  .hbusy      (flags.hbusy),
  .in_len     (in_len),
  .out_pos    (out_pos),
  .out_len    (out_len)
);

// File: tb/bt_host_window_tb.sv
module bt_host_window_tb;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    host_addr = '0;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata;
  logic          req_pulse;
  logic [CW-1:0] req_len;
  logic [AW-1:0] eng_in_addr = '0;
  logic [7:0]    eng_in_data;
  logic          eng_out_we = 1'b0;
  logic [AW-1:0] eng_out_addr = '0;
  logic [7:0]    eng_out_data = '0;
  logic          eng_commit = 1'b0;
  logic [CW-1:0] eng_commit_len = '0;
  logic          eng_sms_set = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  bt_host_window #(.DEPTH(DEPTH)) u_dut (.*);

  // behavioural reference model
  int inbuf [DEPTH];
  int outbuf [DEPTH];
  int m_inlen, m_outpos, m_outlen;
  bit m_bbusy, m_hbusy, m_sms, m_rsp, m_pulse;
  int m_rdata = 8'hFF;

  always @(posedge clk) begin
    if (rst) begin
      m_inlen = 0; m_outpos = 0; m_outlen = 0;
      m_bbusy = 0; m_hbusy = 0; m_sms = 0; m_rsp = 0; m_pulse = 0;
      m_rdata = 8'hFF;
    end else begin
      m_pulse = 0;
      if (host_rd) begin
        if (host_addr == 0)
          m_rdata = (m_bbusy << 7) | (m_hbusy << 6) | (m_sms << 4) | (m_rsp << 3);
        else if (host_addr == 2) m_rdata = 8'h00;
        else if (host_addr == 3) m_rdata = 8'hFF;
        else if (m_outpos < m_outlen) begin
          m_rdata = outbuf[m_outpos];
          m_outpos++;
          if (m_outpos == m_outlen) begin m_outpos = 0; m_outlen = 0; end
        end else m_rdata = 8'hFF;
      end
      if (host_wr && host_addr == 0) begin
        if (host_wdata[0]) m_inlen = 0;
        if (host_wdata[1]) m_outpos = 0;
        if (host_wdata[3]) m_rsp = 0;
        if (host_wdata[4]) m_sms = 0;
        if (host_wdata[6]) m_hbusy = !m_hbusy;
        if (host_wdata[2]) begin m_bbusy = 1; m_pulse = 1; end
      end
      if (host_wr && host_addr == 1) begin
        if (m_inlen < DEPTH) inbuf[m_inlen] = host_wdata;
        if (m_inlen < CMAX) m_inlen++;
      end
      if (eng_out_we) outbuf[eng_out_addr] = eng_out_data;
      if (eng_commit) begin
        m_outlen = (eng_commit_len > DEPTH) ? DEPTH : int'(eng_commit_len);
        m_outpos = 0;
        m_rsp = 1;
        if (!(host_wr && host_addr == 0 && host_wdata[2])) m_bbusy = 0;
      end
      if (eng_sms_set) m_sms = 1;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_req, " rdata"}, host_rdata, m_rdata);
      chk("R7 pulse", req_pulse, m_pulse);
      chk("R3 count", req_len, m_inlen);
    end
  end

  task automatic hw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; v = host_rdata;
  endtask

  task automatic eload(input int n, input logic [7:0] base, input int clen);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); eng_out_we = 1'b1; eng_out_addr = AW'(i); eng_out_data = base + 8'(i);
    end
    @(negedge clk); eng_out_we = 1'b0; eng_commit = 1'b1; eng_commit_len = CW'(clen);
    @(negedge clk); eng_commit = 1'b0;
  endtask

  task automatic peek(input int a, input int exp);
    @(negedge clk); eng_in_addr = AW'(a);
    @(negedge clk); chk("R12 inbound port", eng_in_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    hr(0, v); chk("R1 control after reset", v, 8'h00);
    hr(1, v); chk("R1 data after reset", v, 8'hFF);
    chk("R1 count after reset", req_len, 0);

    cur_req = "R3";
    for (int i = 0; i < 5; i++) hw(1, 8'h10 + 8'(i));
    chk("R3 count after 5 writes", req_len, 5);
    for (int i = 0; i < 5; i++) peek(i, 8'h10 + i);

    cur_req = "R7";
    @(negedge clk); host_addr = 0; host_wdata = 8'h04; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0; chk("R7 pulse high", req_pulse, 1);
    @(negedge clk); chk("R7 pulse one cycle", req_pulse, 0);
    hr(0, v); chk("R7 busy set", v, 8'h80);

    cur_req = "R4";
    hw(0, 8'h01); chk("R4 write clear", req_len, 0);

    cur_req = "R3";
    for (int i = 0; i < 20; i++) hw(1, 8'h40 + 8'(i));
    chk("R3 overrun count", req_len, 20);
    peek(0, 8'h40); peek(DEPTH - 1, 8'h40 + DEPTH - 1);
    for (int i = 0; i < 15; i++) hw(1, 8'h77);
    chk("R3 saturation", req_len, CMAX);
    peek(DEPTH - 1, 8'h40 + DEPTH - 1);
    hw(0, 8'h01);

    cur_req = "R8";
    eload(4, 8'hC0, 4);
    hr(0, v); chk("R8 commit flags", v, 8'h08);

    cur_req = "R9";
    for (int i = 0; i < 4; i++) begin hr(1, v); chk("R9 drain", v, 8'hC0 + i); end
    hr(1, v); chk("R10 after last byte", v, 8'hFF);
    cur_req = "R10";
    hr(1, v); chk("R10 empty again", v, 8'hFF);

    cur_req = "R11";
    eload(3, 8'hD0, 3);
    hr(1, v); chk("R11 first", v, 8'hD0);
    repeat (5) @(negedge clk);
    hr(1, v); chk("R11 no move while idle", v, 8'hD1);
    cur_req = "R4";
    hw(0, 8'h02);
    for (int i = 0; i < 3; i++) begin hr(1, v); chk("R4 replay after read clear", v, 8'hD0 + i); end
    hr(1, v); chk("R9 auto reset", v, 8'hFF);

    cur_req = "R8";
    eload(DEPTH, 8'h80, 20);
    for (int i = 0; i < DEPTH; i++) begin hr(1, v); chk("R8 clamped drain", v, 8'h80 + i); end
    hr(1, v); chk("R8 clamp end", v, 8'hFF);

    cur_req = "R5";
    hw(0, 8'h08); hr(0, v); chk("R5 rsp clear", v, 8'h00);
    @(negedge clk); eng_sms_set = 1'b1; @(negedge clk); eng_sms_set = 1'b0;
    hr(0, v); chk("R5 sms set", v, 8'h10);
    hw(0, 8'h10); hr(0, v); chk("R5 sms clear", v, 8'h00);

    cur_req = "R6";
    hw(0, 8'h40); hr(0, v); chk("R6 toggle on", v, 8'h40);
    hw(0, 8'h40); hr(0, v); chk("R6 toggle off", v, 8'h00);

    cur_req = "R2";
    hr(2, v); chk("R2 mask offset", v, 8'h00);
    hr(3, v); chk("R2 unused offset", v, 8'hFF);
    hw(2, 8'hFF); hw(3, 8'hFF);
    hr(0, v); chk("R2 control untouched", v, 8'h00);
    chk("R2 count untouched", req_len, 0);
    hr(1, v); chk("R2 data untouched", v, 8'hFF);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule